// File: doc/BRIEF.md
# DMA Channel Address Generator

This block keeps the address state of four DMA channels: a programmed start address and transfer count for each channel, the current position inside the transfer, and two 8-bit page registers that extend the 16-bit channel address to a 31-bit physical address. Software programs the 16-bit values through a byte-wide port. A single shared byte pointer picks the low byte or the high byte of each access, so a 16-bit value takes two accesses.

Each transfer strobe moves the chosen channel forward by one unit. A unit is one byte in byte mode and two bytes in word mode. Reads of the address register give the current position in the programmed direction, and reads of the count register give the remaining length. The physical address of the channel named on the transfer select is always on the output. When a channel finishes its programmed length it gives a one-cycle terminal-count pulse. A parameter picks byte or word operation. In word mode the start address and the length are scaled by two internally. Read values are scaled back down, so software sees the same register values in both modes.

Top module: `dma_addr_gen`

## Requirements
- R1: On the channel port, `reg_addr_i[0]` selects the register (0 = address, 1 = count) and `reg_addr_i[2:1]` gives the channel number.
- R2: Every channel-port read or write uses the low byte while the shared byte pointer is 0 and the high byte while it is 1. The pointer toggles after each such access. `ff_clear_i` forces it to 0 and wins over a toggle in the same cycle.
- R3: A pulse on `init_i[c]` loads channel c's current address with its base address shifted left by the width shift (0 in byte mode, 1 in word mode) and clears its transferred count.
- R4: The address register reads as current address + transferred count when `dir_i[c]` is 0, and as current address − transferred count when `dir_i[c]` is 1.
- R5: The count register reads as (base count shifted left by the width shift) − transferred count, in 18-bit two's complement.
- R6: The read byte is the selected value shifted right by (width shift + 8 × byte pointer), keeping the low 8 bits. It appears on `reg_rdata_o` in the cycle after the read strobe.
- R7: A pulse on `xfer_i` adds 1 << width shift to the transferred count of channel `xfer_ch_i`. The total length is (base count + 1) << width shift. A transfer on a channel that has already reached its total is ignored. If init and transfer hit the same channel in the same cycle, init wins.
- R8: `tc_o[c]` is high for exactly one cycle. That cycle is the one after the transfer that brings channel c's transferred count to its total.
- R9: `phys_addr_o` is combinational for channel `xfer_ch_i`. It is {high page[6:0], page[7:0], low 16 bits of the address value from R4}.
- R10: Page offsets 1, 2, 3 and 7 map to channels 2, 3, 1 and 0. `page_hi_sel_i` = 1 selects the high page register. A write to any other offset changes nothing, and a read of any other offset returns 0. Page read data appears in the cycle after the strobe.
- R11: After reset all registers, the byte pointer, the read data and `tc_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Channel register byte write |
| reg_re_i | input | 1 | Channel register byte read |
| reg_addr_i | input | 3 | Channel (bits 2:1) and register select (bit 0) |
| reg_wdata_i | input | 8 | Write byte |
| reg_rdata_o | output | 8 | Read byte, one cycle after the read |
| ff_clear_i | input | 1 | Clear the shared byte pointer |
| page_we_i | input | 1 | Page register write |
| page_re_i | input | 1 | Page register read |
| page_hi_sel_i | input | 1 | 1 = high page register, 0 = page register |
| page_off_i | input | 3 | Page offset |
| page_wdata_i | input | 8 | Page write byte |
| page_rdata_o | output | 8 | Page read byte, one cycle after the read |
| dir_i | input | 4 | Per-channel direction, 1 = decrement |
| init_i | input | 4 | Per-channel initialise pulse |
| xfer_i | input | 1 | Transfer strobe |
| xfer_ch_i | input | 2 | Channel for the transfer and for the physical address |
| phys_addr_o | output | 31 | Physical address of channel `xfer_ch_i` |
| tc_o | output | 4 | Per-channel terminal-count pulse |

## Verification
Register and page reads are due one clock after the strobe. The bench pushes each expected byte into a queue when it issues the read, and a falling-edge monitor pops and compares the byte only in the cycle after a strobe was registered. The terminal-count pulse is also registered, so the bench samples it at the falling edge right after the transfer strobe, and again one edge later to confirm the pulse has ended. The physical address is combinational and is sampled while the select is stable between edges. A byte-mode instance and a word-mode instance run on the same stimulus and must return identical register bytes, while their physical addresses must differ by the factor of two.

// File: rtl/dma_ag_pkg.sv
`timescale 1ns/1ps
package dma_ag_pkg;
  localparam int unsigned NUM_CH = 4;
  localparam int unsigned CH_W   = $clog2(NUM_CH);
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned VAL_W  = ADDR_W + 2;
  localparam int unsigned HP_W   = 7;
  localparam int unsigned PHYS_W = HP_W + 8 + ADDR_W;

  typedef struct packed {
    logic            valid;
    logic [CH_W-1:0] ch;
  } page_map_t;

  function automatic page_map_t page_lookup(input logic [2:0] off);
    page_map_t m;
    m = '0;
    case (off)
      3'd1: m = '{valid: 1'b1, ch: CH_W'(2)};
      3'd2: m = '{valid: 1'b1, ch: CH_W'(3)};
      3'd3: m = '{valid: 1'b1, ch: CH_W'(1)};
      3'd7: m = '{valid: 1'b1, ch: CH_W'(0)};
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/dma_ag_byteptr.sv
`timescale 1ns/1ps
module dma_ag_byteptr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic access_i,
  input  logic clear_i,
  output logic hi_o
);
  logic hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hi_q <= 1'b0;
    else if (clear_i)  hi_q <= 1'b0;
    else if (access_i) hi_q <= ~hi_q;
  end

  assign hi_o = hi_q;
endmodule

// File: rtl/dma_ag_page.sv
`timescale 1ns/1ps
module dma_ag_page
  import dma_ag_pkg::*;
#(
  parameter int unsigned N = NUM_CH
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic                    re_i,
  input  logic                    hi_sel_i,
  input  logic [2:0]              off_i,
  input  logic [7:0]              wdata_i,
  output logic [7:0]              rdata_o,
  output logic [N-1:0][7:0]       page_o,
  output logic [N-1:0][HP_W-1:0]  hpage_o
);
  logic [N-1:0][7:0] page_q, hpage_q;
  logic [7:0]        rdata_q;
  page_map_t         map;

  assign map = page_lookup(off_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q  <= '0;
      hpage_q <= '0;
      rdata_q <= '0;
    end else begin
      if (we_i && map.valid) begin
        if (hi_sel_i) hpage_q[map.ch] <= wdata_i;
        else          page_q[map.ch]  <= wdata_i;
      end
      if (re_i)
        rdata_q <= !map.valid ? 8'h00 : (hi_sel_i ? hpage_q[map.ch] : page_q[map.ch]);
    end
  end

  assign rdata_o = rdata_q;
  assign page_o  = page_q;
  for (genvar c = 0; c < N; c++) begin : g_hp
    assign hpage_o[c] = hpage_q[c][HP_W-1:0];
  end
endmodule

// File: rtl/dma_ag_chan.sv
`timescale 1ns/1ps
module dma_ag_chan
  import dma_ag_pkg::*;
#(
  parameter int unsigned SHIFT = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_addr_i,
  input  logic             wr_cnt_i,
  input  logic             hi_i,
  input  logic [7:0]       wdata_i,
  input  logic             init_i,
  input  logic             step_i,
  input  logic             dir_i,
  output logic [VAL_W-1:0] addr_val_o,
  output logic [VAL_W-1:0] cnt_val_o,
  output logic             tc_o
);
  localparam logic [VAL_W-1:0] STEP = VAL_W'(1) << SHIFT;

  logic [ADDR_W-1:0] base_addr_q, base_cnt_q;
  logic [VAL_W-1:0]  start_q, done_q;
  logic [VAL_W-1:0]  total, done_nxt;
  logic              full, tc_q;

  assign total    = (VAL_W'(base_cnt_q) + VAL_W'(1)) << SHIFT;
  assign full     = done_q >= total;
  assign done_nxt = done_q + STEP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
    end else begin
      if (wr_addr_i) begin
        if (hi_i) base_addr_q[15:8] <= wdata_i;
        else      base_addr_q[7:0]  <= wdata_i;
      end
      if (wr_cnt_i) begin
        if (hi_i) base_cnt_q[15:8] <= wdata_i;
        else      base_cnt_q[7:0]  <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      done_q  <= '0;
      tc_q    <= 1'b0;
    end else begin
      tc_q <= 1'b0;
      if (init_i) begin
        start_q <= VAL_W'(base_addr_q) << SHIFT;
        done_q  <= '0;
      end else if (step_i && !full) begin
        done_q <= done_nxt;
        tc_q   <= done_nxt >= total;
      end
    end
  end

  assign addr_val_o = dir_i ? (start_q - done_q) : (start_q + done_q);
  assign cnt_val_o  = (VAL_W'(base_cnt_q) << SHIFT) - done_q;
  assign tc_o       = tc_q;
endmodule

// File: rtl/dma_addr_gen.sv
`timescale 1ns/1ps
module dma_addr_gen
  import dma_ag_pkg::*;
#(
  parameter bit WORD_MODE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              ff_clear_i,
  input  logic              page_we_i,
  input  logic              page_re_i,
  input  logic              page_hi_sel_i,
  input  logic [2:0]        page_off_i,
  input  logic [7:0]        page_wdata_i,
  output logic [7:0]        page_rdata_o,
  input  logic [3:0]        dir_i,
  input  logic [3:0]        init_i,
  input  logic              xfer_i,
  input  logic [1:0]        xfer_ch_i,
  output logic [PHYS_W-1:0] phys_addr_o,
  output logic [3:0]        tc_o
);
  localparam int unsigned SHIFT = WORD_MODE ? 1 : 0;

  logic [CH_W-1:0]                sel_ch;
  logic                           sel_cnt, ff_hi;
  logic [NUM_CH-1:0][VAL_W-1:0]   addr_val, cnt_val;
  logic [NUM_CH-1:0][7:0]         page;
  logic [NUM_CH-1:0][HP_W-1:0]    hpage;
  logic [VAL_W-1:0]               rd_val, rd_sh;
  logic [7:0]                     rdata_q;

  assign sel_ch  = reg_addr_i[2:1];
  assign sel_cnt = reg_addr_i[0];

  dma_ag_byteptr u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .access_i (reg_we_i | reg_re_i),
    .clear_i  (ff_clear_i),
    .hi_o     (ff_hi)
  );

  dma_ag_page #(.N(NUM_CH)) u_page (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (page_we_i),
    .re_i     (page_re_i),
    .hi_sel_i (page_hi_sel_i),
    .off_i    (page_off_i),
    .wdata_i  (page_wdata_i),
    .rdata_o  (page_rdata_o),
    .page_o   (page),
    .hpage_o  (hpage)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = sel_ch == CH_W'(c);
    dma_ag_chan #(.SHIFT(SHIFT)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_addr_i  (reg_we_i && hit && !sel_cnt),
      .wr_cnt_i   (reg_we_i && hit && sel_cnt),
      .hi_i       (ff_hi),
      .wdata_i    (reg_wdata_i),
      .init_i     (init_i[c]),
      .step_i     (xfer_i && (xfer_ch_i == CH_W'(c))),
      .dir_i      (dir_i[c]),
      .addr_val_o (addr_val[c]),
      .cnt_val_o  (cnt_val[c]),
      .tc_o       (tc_o[c])
    );
  end

  assign rd_val = sel_cnt ? cnt_val[sel_ch] : addr_val[sel_ch];
  assign rd_sh  = rd_val >> (SHIFT + (ff_hi ? 8 : 0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_re_i) rdata_q <= rd_sh[7:0];
  end

  assign reg_rdata_o = rdata_q;
  assign phys_addr_o = {hpage[xfer_ch_i], page[xfer_ch_i], addr_val[xfer_ch_i][ADDR_W-1:0]};
endmodule

// File: rtl/dma_addr_gen_chk.sv
`timescale 1ns/1ps
module dma_addr_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic       reg_re_i,
  input logic       ff_clear_i,
  input logic       ff_hi_i,
  input logic       page_re_i,
  input logic [2:0] page_off_i,
  input logic [7:0] page_rdata_i,
  input logic       xfer_i,
  input logic [3:0] tc_i
);
  logic bad_off;
  assign bad_off = !(page_off_i == 3'd1 || page_off_i == 3'd2 ||
                     page_off_i == 3'd3 || page_off_i == 3'd7);

  a_r2_ptr_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i || reg_re_i) && !ff_clear_i |=> ff_hi_i != $past(ff_hi_i));

  a_r2_ptr_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ff_clear_i |=> !ff_hi_i);

  a_r10_bad_page_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_re_i && bad_off |=> page_rdata_i == 8'h00);

  a_r8_tc_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_i != 4'b0 |=> (tc_i & $past(tc_i)) == 4'b0);

  a_r8_tc_after_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_i != 4'b0 |-> $past(xfer_i) && $countones(tc_i) == 1);
endmodule

bind dma_addr_gen dma_addr_gen_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_we_i     (reg_we_i),
  .reg_re_i     (reg_re_i),
  .ff_clear_i   (ff_clear_i),
  .ff_hi_i      (ff_hi),
  .page_re_i    (page_re_i),
  .page_off_i   (page_off_i),
  .page_rdata_i (page_rdata_o),
  .xfer_i       (xfer_i),
  .tc_i         (tc_o)
);

// File: tb/dma_addr_gen_tb.sv
`timescale 1ns/1ps
module dma_addr_gen_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       reg_we = 0, reg_re = 0, ff_clear = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic       page_we = 0, page_re = 0, page_hi = 0;
  logic [2:0] page_off = 0;
  logic [7:0] page_wdata = 0;
  logic [3:0] dir = 4'b0100, init = 0;
  logic       xfer = 0;
  logic [1:0] xfer_ch = 0;
  logic [7:0] rdata_b, rdata_w, prdata_b, prdata_w;
  logic [30:0] phys_b, phys_w;
  logic [3:0] tc_b, tc_w;

  int checks = 0, errors = 0;

  dma_addr_gen #(.WORD_MODE(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_re_i(reg_re),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata_b),
    .ff_clear_i(ff_clear), .page_we_i(page_we), .page_re_i(page_re),
    .page_hi_sel_i(page_hi), .page_off_i(page_off), .page_wdata_i(page_wdata),
    .page_rdata_o(prdata_b), .dir_i(dir), .init_i(init), .xfer_i(xfer),
    .xfer_ch_i(xfer_ch), .phys_addr_o(phys_b), .tc_o(tc_b));

  dma_addr_gen #(.WORD_MODE(1'b1)) u_dut_w (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_re_i(reg_re),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata_w),
    .ff_clear_i(ff_clear), .page_we_i(page_we), .page_re_i(page_re),
    .page_hi_sel_i(page_hi), .page_off_i(page_off), .page_wdata_i(page_wdata),
    .page_rdata_o(prdata_w), .dir_i(dir), .init_i(init), .xfer_i(xfer),
    .xfer_ch_i(xfer_ch), .phys_addr_o(phys_w), .tc_o(tc_w));

  typedef struct {
    logic       is_page;
    logic [7:0] exp;
    string      tag;
  } exp_t;
  exp_t q[$];
  logic pend_reg = 0, pend_page = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    pend_reg  <= reg_re;
    pend_page <= page_re;
  end

  // monitor: compares registered read data one cycle after each strobe
  always @(negedge clk) begin
    if (pend_reg || pend_page) begin
      if (q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard underflow actual %0d expected 1", q.size());
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.is_page) begin
          chk({24'd0, prdata_b}, {24'd0, e.exp}, {e.tag, " page byte"});
          chk({24'd0, prdata_w}, {24'd0, e.exp}, {e.tag, " page word"});
        end else begin
          chk({24'd0, rdata_b}, {24'd0, e.exp}, {e.tag, " reg byte"});
          chk({24'd0, rdata_w}, {24'd0, e.exp}, {e.tag, " reg word"});
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    exp_t x;
    x.is_page = 0; x.exp = e; x.tag = tag;
    q.push_back(x);
    reg_re = 1; reg_addr = a;
    @(negedge clk); reg_re = 0;
  endtask

  task automatic pwr(input logic hi, input logic [2:0] o, input logic [7:0] d);
    page_we = 1; page_hi = hi; page_off = o; page_wdata = d;
    @(negedge clk); page_we = 0;
  endtask

  task automatic prd(input logic hi, input logic [2:0] o, input logic [7:0] e, input string tag);
    exp_t x;
    x.is_page = 1; x.exp = e; x.tag = tag;
    q.push_back(x);
    page_re = 1; page_hi = hi; page_off = o;
    @(negedge clk); page_re = 0;
  endtask

  task automatic do_init(input int c);
    init = 4'b0001 << c;
    @(negedge clk); init = 0;
  endtask

  task automatic step(input logic [1:0] c, input logic [3:0] exp_tc, input string tag);
    xfer = 1; xfer_ch = c;
    @(negedge clk); xfer = 0;
    chk({28'd0, tc_b}, {28'd0, exp_tc}, {tag, " tc byte"});
    chk({28'd0, tc_w}, {28'd0, exp_tc}, {tag, " tc word"});
  endtask

  bit done = 0;
  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk({28'd0, tc_b}, 0, "R11 tc");
    chk({1'b0, phys_b}, 0, "R11 phys byte");
    chk({1'b0, phys_w}, 0, "R11 phys word");
    rd(3'd0, 8'h00, "R11 addr lo");
    rd(3'd0, 8'h00, "R11 addr hi");

    // ch1: base address 0x1234, base count 3 (R1 addressing)
    wr(3'd2, 8'h34); wr(3'd2, 8'h12);
    wr(3'd3, 8'h03); wr(3'd3, 8'h00);
    do_init(1);
    rd(3'd2, 8'h34, "R3 addr lo");
    rd(3'd2, 8'h12, "R3 addr hi");
    rd(3'd3, 8'h03, "R5 count lo");
    rd(3'd3, 8'h00, "R5 count hi");
    rd(3'd0, 8'h00, "R1 other channel untouched");
    rd(3'd1, 8'h00, "R1 other channel count");

    // R10 pages
    pwr(1'b0, 3'd3, 8'hAB);
    pwr(1'b1, 3'd3, 8'hFF);
    pwr(1'b0, 3'd4, 8'h55);
    prd(1'b0, 3'd3, 8'hAB, "R10 page ch1");
    prd(1'b1, 3'd3, 8'hFF, "R10 high page ch1");
    prd(1'b0, 3'd4, 8'h00, "R10 invalid offset read");
    prd(1'b0, 3'd1, 8'h00, "R10 invalid write ignored ch2");
    prd(1'b0, 3'd2, 8'h00, "R10 invalid write ignored ch3");
    prd(1'b0, 3'd7, 8'h00, "R10 invalid write ignored ch0");

    xfer_ch = 2'd1;
    #1;
    chk({1'b0, phys_b}, 32'h7FAB1234, "R9 phys byte");
    chk({1'b0, phys_w}, 32'h7FAB2468, "R9 phys word");

    step(2'd1, 4'b0000, "R7 step1");
    rd(3'd2, 8'h35, "R4 addr up lo");
    rd(3'd2, 8'h12, "R4 addr up hi");
    rd(3'd3, 8'h02, "R5 remaining lo");
    rd(3'd3, 8'h00, "R5 remaining hi");
    step(2'd1, 4'b0000, "R7 step2");
    step(2'd1, 4'b0000, "R7 step3");
    step(2'd1, 4'b0010, "R8 terminal count");
    @(negedge clk);
    chk({28'd0, tc_b}, 0, "R8 pulse ends");
    chk({1'b0, phys_b}, 32'h7FAB1238, "R9 phys byte end");
    chk({1'b0, phys_w}, 32'h7FAB2470, "R9 phys word end");
    step(2'd1, 4'b0000, "R7 step past total");
    rd(3'd2, 8'h38, "R7 addr held lo");
    rd(3'd2, 8'h12, "R7 addr held hi");
    rd(3'd3, 8'hFF, "R5 count negative lo");
    rd(3'd3, 8'hFF, "R5 count negative hi");

    // ch2 decrement from 0x0100
    wr(3'd4, 8'h00); wr(3'd4, 8'h01);
    wr(3'd5, 8'h10); wr(3'd5, 8'h00);
    do_init(2);
    step(2'd2, 4'b0000, "R7 dec step1");
    step(2'd2, 4'b0000, "R7 dec step2");
    rd(3'd4, 8'hFE, "R4 addr down lo");
    rd(3'd4, 8'h00, "R4 addr down hi");
    xfer_ch = 2'd2;
    #1;
    chk({1'b0, phys_b}, 32'h000000FE, "R9 phys dec byte");
    chk({1'b0, phys_w}, 32'h000001FC, "R9 phys dec word");

    // R2 pointer clear after a lone low byte
    wr(3'd6, 8'h77);
    ff_clear = 1; @(negedge clk); ff_clear = 0;
    wr(3'd6, 8'h66); wr(3'd6, 8'h99);
    do_init(3);
    rd(3'd6, 8'h66, "R2 clear then low");
    rd(3'd6, 8'h99, "R2 then high");

    // R3 re-init of ch1 clears progress
    do_init(1);
    rd(3'd2, 8'h34, "R3 reinit addr lo");
    rd(3'd2, 8'h12, "R3 reinit addr hi");
    rd(3'd3, 8'h03, "R3 reinit count lo");
    rd(3'd3, 8'h00, "R3 reinit count hi");

    // R7 init wins over same-cycle transfer
    xfer = 1; xfer_ch = 2'd1; init = 4'b0010;
    @(negedge clk); xfer = 0; init = 0;
    rd(3'd3, 8'h03, "R7 init priority");
    rd(3'd3, 8'h00, "R7 init priority hi");

    repeat (3) @(negedge clk);
    chk(q.size(), 0, "R6 all reads returned");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule